// File: doc/BRIEF.md
# Shared Interrupt Source Controller

The block collects a set of shared interrupt inputs, turns each into a pending bit according to its own sense setting, and drives one request line per target core. Each source can be level sensed or edge latched. A per-source polarity bit selects the active level or edge, and a dual-edge bit makes an edge source latch on both transitions. Software programs everything through a small 32-bit word-addressed register bus. Writes complete in the cycle they are presented. Read data returns one cycle after the request.

Masks never change through a read-modify-write. One register sets mask bits and another clears them, and a zero bit in either leaves the mask alone. A wedge register lets software force a source pending, which is how one core raises an interrupt on another. The same register retires a latched edge, which is how an edge is acknowledged. Each source has a routing entry made of a pin number with a valid flag, plus exactly one target core. A core's request line is the registered OR of every source that is pending, unmasked, validly mapped and routed to that core.

The bus side is a two-state machine. `BUS_IDLE` moves to `BUS_RESP` on a read request. `BUS_RESP` stays in `BUS_RESP` on a further read request and returns to `BUS_IDLE` otherwise. `bus_rvalid` is high exactly in `BUS_RESP`.

Top module: `sic_ctrl`

## Requirements
- R1: After reset the following hold:
  - every polarity bit is 1 (active high);
  - every trigger bit is 0 (level);
  - every dual-edge bit is 0;
  - every mask bit is 0 (masked);
  - every pin entry reads 0 (invalid, pin 0);
  - every core entry reads 1 (core 0);
  - `core_irq` and `bus_rvalid` are 0.
- R2: The configuration word at region 0 reads the source-count field (N/8 − 1) in bits [7:0] and the core-count field (CORES − 1) in bits [15:8]. With the defaults this word is 0x0000_0303.
- R3: A write to the set-mask region (4) ORs the data into the mask word. A write to the clear-mask region (5) clears the mask bits where the data is 1. Data bits written as 0 leave the mask unchanged. Both regions read back the mask.
- R4: The pending word at region 6 and the masked-pending word at region 7 are defined as follows:
  - For a level source (trigger bit 0), pending equals the input when the polarity bit is 1 and the inverted input when it is 0, with no added delay.
  - The masked-pending word is pending AND mask.
- R5: An edge source (trigger bit 1, dual bit 0) is handled as follows:
  - It passes through a 2-flop synchronizer.
  - It latches pending on a rising edge when its polarity bit is 1 and on a falling edge when it is 0.
  - The latch is sticky: the input returning to its idle level does not clear it.
- R6: With its dual-edge bit set, an edge source latches on both rising and falling transitions, whatever its polarity bit.
- R7: Wedge writes (region 8) work as follows:
  - Bit 31 = 1 with the source index in bits [4:0] forces the source's latch set.
  - Bit 31 = 0 clears the latch.
  - When a clear and a newly detected edge fall in the same cycle, the edge wins and the source stays pending.
- R8: The request lines are computed as follows:
  - `core_irq[c]` is the OR over all sources that are pending, unmasked, have pin-entry valid bit 31 set (region 9) and are routed to core c.
  - The output is registered: it follows a change in that condition by one clock.
- R9: Core routing (region 10) is written as a bitmap and behaves as follows:
  - The lowest set bit selects the core.
  - A write of all zeros is ignored.
  - The readback is a one-hot bitmap, so a source always targets exactly one core.
- R10: `bus_rvalid` is high in the cycle after a read request and only then, carrying the addressed word on `bus_rdata`. Writes never raise `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | N | Shared interrupt inputs |
| bus_req | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 14 | Word address: [13:10] region, [9:0] index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| core_irq | output | CORES | Per-core interrupt request |

## Verification
The delicate overlap is between a wedge clear write and a newly synchronized edge on the same source in the same clock. The bench first forces the source pending through the wedge. It then toggles the input two cycles before issuing the clear, so that the edge detector fires exactly on the edge where the clear is sampled. A following read of the pending word must still show the source set. A second clear with the input quiet must drop the source, which confirms that the first result came from the edge and not from a lost write.

// File: rtl/sic_pkg.sv
package sic_pkg;

    typedef enum logic [3:0] {
        RG_CFG   = 4'd0,
        RG_POL   = 4'd1,
        RG_TRIG  = 4'd2,
        RG_DUAL  = 4'd3,
        RG_MSET  = 4'd4,
        RG_MCLR  = 4'd5,
        RG_PEND  = 4'd6,
        RG_MPEND = 4'd7,
        RG_WEDGE = 4'd8,
        RG_PIN   = 4'd9,
        RG_CORE  = 4'd10
    } region_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;

    localparam int WEDGE_SET_BIT = 31;
    localparam int PIN_VALID_BIT = 31;
    localparam int CFG_CORE_LSB  = 8;

endpackage

// File: rtl/sic_sense.sv
module sic_sense #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_in,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] dual,
    input  logic [N-1:0] wset_vec,
    input  logic [N-1:0] wclr_vec,
    output logic [N-1:0] pend
);

    for (genvar s = 0; s < N; s++) begin : g_src
        logic sync1, sync2, sync3, latch_q;
        logic rise, fall, det;

        always_comb begin
            rise = sync2 & ~sync3;
            fall = ~sync2 & sync3;
            det  = dual[s] ? (rise | fall) : (pol[s] ? rise : fall);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync1   <= 1'b0;
                sync2   <= 1'b0;
                sync3   <= 1'b0;
                latch_q <= 1'b0;
            end else begin
                sync1   <= src_in[s];
                sync2   <= sync1;
                sync3   <= sync2;
                // a fresh edge or a wedge set outranks a wedge clear
                latch_q <= (latch_q & ~wclr_vec[s]) | wset_vec[s] | (trig[s] & det);
            end
        end

        assign pend[s] = trig[s] ? latch_q : ~(src_in[s] ^ pol[s]);
    end

endmodule

// File: rtl/sic_route.sv
module sic_route #(
    parameter int N      = 32,
    parameter int CORES  = 4,
    parameter int CORE_W = $clog2(CORES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N-1:0]                 pend,
    input  logic [N-1:0]                 mask,
    input  logic [N-1:0]                 pin_valid,
    input  logic [N-1:0][CORE_W-1:0]     core_idx,
    output logic [CORES-1:0]             core_irq
);

    logic [N-1:0]     live;
    logic [CORES-1:0] irq_d;

    assign live = pend & mask & pin_valid;

    for (genvar c = 0; c < CORES; c++) begin : g_core
        logic [N-1:0] hit;
        always_comb begin
            for (int s = 0; s < N; s++) begin
                hit[s] = live[s] && (core_idx[s] == CORE_W'(c));
            end
        end
        assign irq_d[c] = |hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_irq <= '0;
        else        core_irq <= irq_d;
    end

endmodule

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int N      = 32,
    parameter int CORES  = 4,
    parameter int PIN_W  = 6,
    parameter int CORE_W = $clog2(CORES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_req,
    input  logic                     bus_we,
    input  logic [13:0]              bus_waddr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     bus_rvalid,
    input  logic [N-1:0]             pend,
    output logic [N-1:0]             pol,
    output logic [N-1:0]             trig,
    output logic [N-1:0]             dual,
    output logic [N-1:0]             mask,
    output logic [N-1:0]             pin_valid,
    output logic [N-1:0][CORE_W-1:0] core_idx,
    output logic [N-1:0]             wset_vec,
    output logic [N-1:0]             wclr_vec
);

    localparam int NW    = N / 32;
    localparam int SRC_W = $clog2(N);
    localparam int IDX_W = 10;

    region_e            region;
    logic [IDX_W-1:0]   idx;
    logic [SRC_W-1:0]   idx_src;
    logic               idx_ok;
    logic               wr, rd;
    logic [SRC_W-1:0]   wsrc;
    logic               wsrc_ok;
    logic [CORE_W-1:0]  low_core;
    logic [31:0]        rd_word;
    logic [N-1:0][PIN_W-1:0] pin_num_q;
    bus_state_e         st_q, st_d;

    assign region  = region_e'(bus_waddr[13:10]);
    assign idx     = bus_waddr[IDX_W-1:0];
    assign idx_src = idx[SRC_W-1:0];
    assign idx_ok  = int'(idx) < N;
    assign wr      = bus_req & bus_we;
    assign rd      = bus_req & ~bus_we;
    assign wsrc    = bus_wdata[SRC_W-1:0];
    assign wsrc_ok = int'(wsrc) < N;

    function automatic logic [CORE_W-1:0] first_core(input logic [CORES-1:0] v);
        first_core = '0;
        for (int c = CORES - 1; c >= 0; c--) begin
            if (v[c]) first_core = CORE_W'(c);
        end
    endfunction

    assign low_core = first_core(bus_wdata[CORES-1:0]);

    // wedge strobes, one cycle wide, applied by the sense stage
    always_comb begin
        wset_vec = '0;
        wclr_vec = '0;
        if (wr && region == RG_WEDGE && wsrc_ok) begin
            if (bus_wdata[WEDGE_SET_BIT]) wset_vec[wsrc] = 1'b1;
            else                          wclr_vec[wsrc] = 1'b1;
        end
    end

    // configuration storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol       <= '1;
            trig      <= '0;
            dual      <= '0;
            mask      <= '0;
            pin_valid <= '0;
            pin_num_q <= '0;
            core_idx  <= '0;
        end else if (wr) begin
            case (region)
                RG_POL:  for (int w = 0; w < NW; w++)
                             if (idx == IDX_W'(w)) pol[w*32 +: 32] <= bus_wdata;
                RG_TRIG: for (int w = 0; w < NW; w++)
                             if (idx == IDX_W'(w)) trig[w*32 +: 32] <= bus_wdata;
                RG_DUAL: for (int w = 0; w < NW; w++)
                             if (idx == IDX_W'(w)) dual[w*32 +: 32] <= bus_wdata;
                RG_MSET: for (int w = 0; w < NW; w++)
                             if (idx == IDX_W'(w))
                                 mask[w*32 +: 32] <= mask[w*32 +: 32] | bus_wdata;
                RG_MCLR: for (int w = 0; w < NW; w++)
                             if (idx == IDX_W'(w))
                                 mask[w*32 +: 32] <= mask[w*32 +: 32] & ~bus_wdata;
                RG_PIN: if (idx_ok) begin
                    pin_valid[idx_src] <= bus_wdata[PIN_VALID_BIT];
                    pin_num_q[idx_src] <= bus_wdata[PIN_W-1:0];
                end
                RG_CORE: if (idx_ok && (|bus_wdata[CORES-1:0])) begin
                    core_idx[idx_src] <= low_core;
                end
                default: ;
            endcase
        end
    end

    // read multiplexer
    always_comb begin
        rd_word = '0;
        case (region)
            RG_CFG: begin
                rd_word[7:0] = 8'(N / 8 - 1);
                rd_word[CFG_CORE_LSB +: 8] = 8'(CORES - 1);
            end
            RG_POL:   for (int w = 0; w < NW; w++)
                          if (idx == IDX_W'(w)) rd_word = pol[w*32 +: 32];
            RG_TRIG:  for (int w = 0; w < NW; w++)
                          if (idx == IDX_W'(w)) rd_word = trig[w*32 +: 32];
            RG_DUAL:  for (int w = 0; w < NW; w++)
                          if (idx == IDX_W'(w)) rd_word = dual[w*32 +: 32];
            RG_MSET, RG_MCLR: for (int w = 0; w < NW; w++)
                          if (idx == IDX_W'(w)) rd_word = mask[w*32 +: 32];
            RG_PEND:  for (int w = 0; w < NW; w++)
                          if (idx == IDX_W'(w)) rd_word = pend[w*32 +: 32];
            RG_MPEND: for (int w = 0; w < NW; w++)
                          if (idx == IDX_W'(w))
                              rd_word = pend[w*32 +: 32] & mask[w*32 +: 32];
            RG_PIN: if (idx_ok) begin
                rd_word[PIN_VALID_BIT] = pin_valid[idx_src];
                rd_word[PIN_W-1:0]     = pin_num_q[idx_src];
            end
            RG_CORE: if (idx_ok) begin
                rd_word[CORES-1:0] = CORES'(1) << core_idx[idx_src];
            end
            default: ;
        endcase
    end

    // bus response state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: st_d = rd ? BUS_RESP : BUS_IDLE;
            BUS_RESP: st_d = rd ? BUS_RESP : BUS_IDLE;
            default:  st_d = BUS_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_word;
    end

    assign bus_rvalid = (st_q == BUS_RESP);

endmodule

// File: rtl/sic_ctrl.sv
module sic_ctrl #(
    parameter int N     = 32,
    parameter int CORES = 4,
    parameter int PIN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     src_in,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [13:0]      bus_waddr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             bus_rvalid,
    output logic [CORES-1:0] core_irq
);

    localparam int CORE_W = $clog2(CORES);

    logic [N-1:0]             pend_w, pol_w, trig_w, dual_w, mask_w, pin_valid_w;
    logic [N-1:0]             wset_w, wclr_w;
    logic [N-1:0][CORE_W-1:0] core_idx_w;

    sic_regs #(.N(N), .CORES(CORES), .PIN_W(PIN_W), .CORE_W(CORE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_waddr  (bus_waddr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pend       (pend_w),
        .pol        (pol_w),
        .trig       (trig_w),
        .dual       (dual_w),
        .mask       (mask_w),
        .pin_valid  (pin_valid_w),
        .core_idx   (core_idx_w),
        .wset_vec   (wset_w),
        .wclr_vec   (wclr_w)
    );

    sic_sense #(.N(N)) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .pol      (pol_w),
        .trig     (trig_w),
        .dual     (dual_w),
        .wset_vec (wset_w),
        .wclr_vec (wclr_w),
        .pend     (pend_w)
    );

    sic_route #(.N(N), .CORES(CORES), .CORE_W(CORE_W)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend_w),
        .mask      (mask_w),
        .pin_valid (pin_valid_w),
        .core_idx  (core_idx_w),
        .core_irq  (core_irq)
    );

endmodule

// File: rtl/sic_ctrl_chk.sv
module sic_ctrl_chk #(
    parameter int N     = 32,
    parameter int CORES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_we,
    input logic [13:0]      bus_waddr,
    input logic [31:0]      bus_wdata,
    input logic             bus_rvalid,
    input logic [CORES-1:0] core_irq,
    input logic [N-1:0]     mask_w,
    input logic [N-1:0]     trig_w,
    input logic [N-1:0]     pend_w
);

    localparam int SRC_W = $clog2(N);

    logic wr_word0;
    assign wr_word0 = bus_req && bus_we && (bus_waddr[9:0] == 10'd0);

    p_rvalid_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    p_rvalid_only_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid);

    p_quiet_when_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w == '0) |=> (core_irq == '0));

    p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word0 && bus_waddr[13:10] == 4'd4)
        |=> (mask_w[31:0] == ($past(mask_w[31:0]) | $past(bus_wdata))));

    p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word0 && bus_waddr[13:10] == 4'd5)
        |=> (mask_w[31:0] == ($past(mask_w[31:0]) & ~$past(bus_wdata))));

    p_wedge_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_waddr[13:10] == 4'd8 && bus_wdata[31]
         && trig_w[bus_wdata[SRC_W-1:0]])
        |=> pend_w[$past(bus_wdata[SRC_W-1:0])]);

endmodule

bind sic_ctrl sic_ctrl_chk #(.N(N), .CORES(CORES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_waddr  (bus_waddr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .core_irq   (core_irq),
    .mask_w     (mask_w),
    .trig_w     (trig_w),
    .pend_w     (pend_w)
);

// File: tb/test_sic_ctrl.sv
module test_sic_ctrl;

    localparam int N = 32;
    localparam int CORES = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     src_in = '0;
    logic             bus_req = 1'b0;
    logic             bus_we = 1'b0;
    logic [13:0]      bus_waddr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             bus_rvalid;
    logic [CORES-1:0] core_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sic_ctrl #(.N(N), .CORES(CORES), .PIN_W(6)) i_sic_ctrl (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .bus_req(bus_req), .bus_we(bus_we), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .core_irq(core_irq)
    );

    typedef struct packed {
        logic        rd;
        logic [13:0] wa;
        logic [31:0] wd;
        logic [31:0] src;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, {4'd0,  10'd0}, 32'h0,        32'h0,  32'h0000_0303, 8'd2}, // R2 config
        '{1'b1, {4'd1,  10'd0}, 32'h0,        32'h0,  32'hFFFF_FFFF, 8'd1}, // R1 polarity
        '{1'b1, {4'd2,  10'd0}, 32'h0,        32'h0,  32'h0,         8'd1}, // R1 trigger
        '{1'b1, {4'd3,  10'd0}, 32'h0,        32'h0,  32'h0,         8'd1}, // R1 dual
        '{1'b1, {4'd4,  10'd0}, 32'h0,        32'h0,  32'h0,         8'd1}, // R1 mask
        '{1'b1, {4'd10, 10'd5}, 32'h0,        32'h0,  32'h1,         8'd1}, // R1 core map
        '{1'b1, {4'd9,  10'd5}, 32'h0,        32'h0,  32'h0,         8'd1}, // R1 pin map
        '{1'b1, {4'd6,  10'd0}, 32'h0,        32'h0,  32'h0,         8'd4}, // R4 level idle
        '{1'b1, {4'd6,  10'd0}, 32'h0,        32'hF0, 32'hF0,        8'd4}, // R4 level high
        '{1'b0, {4'd4,  10'd0}, 32'h30,       32'hF0, 32'h0,         8'd3}, // R3 set
        '{1'b1, {4'd4,  10'd0}, 32'h0,        32'hF0, 32'h30,        8'd3}, // R3
        '{1'b0, {4'd4,  10'd0}, 32'h01,       32'hF0, 32'h0,         8'd3}, // R3 set more
        '{1'b1, {4'd5,  10'd0}, 32'h0,        32'hF0, 32'h31,        8'd3}, // R3 read via clr
        '{1'b0, {4'd5,  10'd0}, 32'h10,       32'hF0, 32'h0,         8'd3}, // R3 clear
        '{1'b1, {4'd4,  10'd0}, 32'h0,        32'hF0, 32'h21,        8'd3}, // R3
        '{1'b1, {4'd7,  10'd0}, 32'h0,        32'hF0, 32'h20,        8'd4}, // R4 masked pend
        '{1'b0, {4'd1,  10'd0}, 32'hFFFF_FF7F, 32'hF0, 32'h0,        8'd4}, // R4 active low
        '{1'b1, {4'd6,  10'd0}, 32'h0,        32'hF0, 32'h70,        8'd4}  // R4
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [13:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [13:0] a, output logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_waddr = a;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0;
        check("R10 rvalid after read", 32'(bus_rvalid), 32'h1);
        d = bus_rdata;
    endtask

    function automatic logic [13:0] ad(input int rg, input int ix);
        return {4'(rg), 10'(ix)};
    endfunction

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        summary();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 core_irq at reset", 32'(core_irq), 32'h0);
        check("R1 rvalid at reset", 32'(bus_rvalid), 32'h0);

        for (int i = 0; i < NV; i++) begin
            src_in = VECS[i].src;
            repeat (3) @(negedge clk);
            if (VECS[i].rd) begin
                bus_rd(VECS[i].wa, d);
                n_chk++;
                if (d !== VECS[i].exp) begin
                    n_fail++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h",
                             VECS[i].req, i, d, VECS[i].exp);
                end
            end else begin
                bus_wr(VECS[i].wa, VECS[i].wd);
                check("R10 no rvalid after write", 32'(bus_rvalid), 32'h0);
            end
        end

        // R8 routing: source 5 pending and unmasked, pin map invalid
        check("R8 invalid pin blocks", 32'(core_irq), 32'h0);
        bus_wr(ad(9, 5), 32'h8000_0002);
        bus_wr(ad(10, 5), 32'h4);
        @(negedge clk);
        check("R8 core2 request", 32'(core_irq), 32'h4);
        src_in[5] = 1'b0;
        @(negedge clk);
        check("R8 level drop one cycle", 32'(core_irq), 32'h0);
        src_in[5] = 1'b1;
        @(negedge clk);
        check("R8 level return", 32'(core_irq), 32'h4);
        bus_wr(ad(5, 0), 32'h20);
        @(negedge clk);
        check("R8 masked off", 32'(core_irq), 32'h0);
        bus_rd(ad(9, 5), d);
        check("R8 pin readback", d, 32'h8000_0002);

        // R9 core map
        bus_wr(ad(10, 5), 32'hC);
        bus_rd(ad(10, 5), d);
        check("R9 lowest bit wins", d, 32'h4);
        bus_wr(ad(10, 5), 32'h0);
        bus_rd(ad(10, 5), d);
        check("R9 zero write ignored", d, 32'h4);
        bus_wr(ad(10, 5), 32'h8);
        bus_rd(ad(10, 5), d);
        check("R9 core3", d, 32'h8);

        // R5 edge, active high, source 8 on core 1
        bus_wr(ad(2, 0), 32'h100);
        bus_wr(ad(4, 0), 32'h100);
        bus_wr(ad(9, 8), 32'h8000_0000);
        bus_wr(ad(10, 8), 32'h2);
        src_in[8] = 1'b1; settle();
        bus_rd(ad(6, 0), d);
        check("R5 rising latches", 32'(d[8]), 32'h1);
        check("R8 edge source to core1", 32'(core_irq), 32'h2);
        src_in[8] = 1'b0; settle();
        bus_rd(ad(6, 0), d);
        check("R5 sticky", 32'(d[8]), 32'h1);
        bus_wr(ad(8, 0), 32'h0000_0008);
        bus_rd(ad(6, 0), d);
        check("R7 wedge clear", 32'(d[8]), 32'h0);
        check("R8 request drops", 32'(core_irq), 32'h0);
        src_in[8] = 1'b1; settle();
        bus_wr(ad(8, 0), 32'h0000_0008);
        src_in[8] = 1'b0; settle();
        bus_rd(ad(6, 0), d);
        check("R5 falling ignored when active high", 32'(d[8]), 32'h0);

        // R5 active low
        bus_wr(ad(1, 0), 32'hFFFF_FE7F);
        src_in[8] = 1'b1; settle();
        bus_rd(ad(6, 0), d);
        check("R5 rising ignored when active low", 32'(d[8]), 32'h0);
        src_in[8] = 1'b0; settle();
        bus_rd(ad(6, 0), d);
        check("R5 falling latches when active low", 32'(d[8]), 32'h1);
        bus_wr(ad(8, 0), 32'h0000_0008);

        // R6 dual edge
        bus_wr(ad(3, 0), 32'h100);
        src_in[8] = 1'b1; settle();
        bus_rd(ad(6, 0), d);
        check("R6 dual rising", 32'(d[8]), 32'h1);
        bus_wr(ad(8, 0), 32'h0000_0008);
        src_in[8] = 1'b0; settle();
        bus_rd(ad(6, 0), d);
        check("R6 dual falling", 32'(d[8]), 32'h1);
        bus_wr(ad(8, 0), 32'h0000_0008);

        // R7 wedge set on source 20
        bus_wr(ad(2, 0), 32'h0010_0100);
        bus_wr(ad(8, 0), 32'h8000_0014);
        bus_rd(ad(6, 0), d);
        check("R7 wedge set", 32'(d[20]), 32'h1);
        bus_wr(ad(8, 0), 32'h0000_0014);
        bus_rd(ad(6, 0), d);
        check("R7 wedge clear src20", 32'(d[20]), 32'h0);

        // R7 clear and new edge in the same cycle: edge wins
        bus_wr(ad(8, 0), 32'h8000_0008);
        src_in[8] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr(ad(8, 0), 32'h0000_0008);
        bus_rd(ad(6, 0), d);
        check("R7 edge beats clear", 32'(d[8]), 32'h1);
        bus_wr(ad(8, 0), 32'h0000_0008);
        bus_rd(ad(6, 0), d);
        check("R7 quiet clear retires", 32'(d[8]), 32'h0);

        summary();
    end

endmodule